// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a link to a 20-bit serial converter. The converter sends a 24-bit frame: two status bits, a sign bit, a range bit and then 20 result bits. When asked to take a reading, the reader drives chip select low and then watches the serial data line. The converter holds that line high while a conversion is still running. Once the line drops, the reader produces a serial clock from a programmable divider, and it takes in one bit on each rising edge of that clock.

When the frame is complete, the reader raises chip select and decodes the status bits into a signed result. That result reaches 12.5% of full scale above the top of the normal range and 12.5% below zero. It is presented with overrange and underrange flags and with a one-cycle valid strobe. A longer frame of 32 clocks is also supported, for hosts that expect 32 clocks; in that frame the 8 trailing bits must all read 1. A programmable timeout limits how long the reader waits for the end of a conversion.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_o` is 0, and `busy_o`, `valid_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse while idle drives `cs_no` low. While `sdo_i` stays high (conversion in progress), no serial clock edge is produced.
- R3: Each serial clock half-period lasts `div_i` system cycles, with 0 treated as 1. The clock idles low and toggles only while `cs_no` is 0.
- R4: After `sdo_i` is seen low, the reader produces exactly 24 rising clock edges, or 32 when `long_frame_i` is 1. It samples `sdo_i` on each rising edge, MSB first. `cs_no` rises together with the falling edge that follows the last rising edge.
- R5: The frame bits in order are: end-of-conversion, dummy, sign (s), range (x), then 20 data bits d. The 22-bit signed `result_o` is d when s=1 and x=0. It is 2^20+d when s=1 and x=1. It is d-2^20 when s=0 and x=1.
- R6: `over_o` is 1 when s=1 and x=1. `under_o` is 1 when s=0 and x=1. The result and both flags change together with a `valid_o` pulse that lasts exactly one cycle.
- R7: `frame_err_o` is 1 with the result when the dummy bit (second frame bit) or the end-of-conversion bit reads 1. The result is still decoded.
- R8: In the 32-clock frame, `frame_err_o` is also 1 when any of the last 8 bits reads 0.
- R9: If `sdo_i` is still high on the wait cycle where the count of earlier high wait cycles equals `timeout_i`, the reader raises `cs_no` and pulses `timeout_o` for one cycle, with no `valid_o`. A low `sdo_i` on that same cycle starts the frame instead.
- R10: `start_i` has no effect while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one reading |
| long_frame_i | input | 1 | 1: 32-clock frame with all-ones trailer |
| div_i | input | 8 | Serial clock half-period in system cycles |
| timeout_i | input | 16 | Limit on wait cycles for end of conversion |
| sdo_i | input | 1 | Serial data from converter |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock to converter |
| busy_o | output | 1 | Reading in progress |
| valid_o | output | 1 | One-cycle strobe for a new result |
| result_o | output | 22 | Signed extended-range result |
| over_o | output | 1 | Input above full scale |
| under_o | output | 1 | Input below zero |
| frame_err_o | output | 1 | Status or trailer bits malformed |
| timeout_o | output | 1 | One-cycle strobe: wait for conversion aborted |

## Verification
The end of a conversion and the expiry of the timeout can occur on the same wait cycle. In that case the low data line must win, and the frame must be clocked. The bench provokes this by making the converter model finish its conversion on exactly the wait cycle whose count equals `timeout_i`. It checks that a valid result with the right value appears and that `timeout_o` stays low. A second run, with the conversion finishing one cycle later, must produce the timeout with no serial clock edges.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] last;
  logic             tick;

  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick   = en_i && (ph_q == last);
  assign rise_o = tick && !sck_o;
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      sck_o <= 1'b0;
    end else if (!en_i) begin
      ph_q  <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      ph_q  <= '0;
      sck_o <= !sck_o;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int FR_W  = 32,
  parameter int CNT_W = $clog2(FR_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [FR_W-1:0]  frame_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      cnt_o   <= '0;
    end else if (clr_i) begin
      frame_o <= '0;
      cnt_o   <= '0;
    end else if (shift_i) begin
      frame_o <= {frame_o[FR_W-2:0], bit_i};
      cnt_o   <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_decode.sv
module adc_frame_decode #(
  parameter int DATA_W = 20,
  parameter int TRL_W  = 8,
  localparam int SHORT_W = DATA_W + 4,
  localparam int FR_W    = SHORT_W + TRL_W,
  localparam int RES_W   = DATA_W + 2
) (
  input  logic [FR_W-1:0]  frame_i,
  input  logic             long_i,
  output logic [RES_W-1:0] result_o,
  output logic             over_o,
  output logic             under_o,
  output logic             err_o
);
  logic [SHORT_W-1:0] stat;
  logic               sig, exr, trail_ok;
  logic [DATA_W-1:0]  dat;

  // long frame is left-aligned: status+data first, trailer in the low bits
  assign stat     = long_i ? frame_i[FR_W-1 -: SHORT_W] : frame_i[SHORT_W-1:0];
  assign trail_ok = !long_i || (&frame_i[TRL_W-1:0]);
  assign sig      = stat[DATA_W+1];
  assign exr      = stat[DATA_W];
  assign dat      = stat[DATA_W-1:0];

  always_comb begin
    if (!sig && exr) result_o = {2'b11, dat};
    else             result_o = {1'b0, sig & exr, dat};
  end

  assign over_o  = sig && exr;
  assign under_o = !sig && exr;
  assign err_o   = stat[SHORT_W-1] || stat[SHORT_W-2] || !trail_ok;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W = 20,
  parameter int TRL_W  = 8,
  parameter int DIV_W  = 8,
  parameter int TO_W   = 16,
  localparam int SHORT_W = DATA_W + 4,
  localparam int FR_W    = SHORT_W + TRL_W,
  localparam int RES_W   = DATA_W + 2,
  localparam int CNT_W   = $clog2(FR_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             long_frame_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             sdo_i,
  output logic             cs_no,
  output logic             sck_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             over_o,
  output logic             under_o,
  output logic             frame_err_o,
  output logic             timeout_o
);
  import adc_rd_pkg::*;

  rd_state_e        state_q;
  logic             long_q;
  logic [DIV_W-1:0] div_q;
  logic [TO_W-1:0]  wait_q;
  logic             sck_en, rise, fall, clr, last_fall;
  logic [FR_W-1:0]  frame;
  logic [CNT_W-1:0] bit_cnt, nbits;
  logic [RES_W-1:0] dec_res;
  logic             dec_over, dec_under, dec_err;

  assign sck_en    = (state_q == ST_SHIFT);
  assign clr       = (state_q == ST_IDLE) && start_i;
  assign nbits     = long_q ? CNT_W'(FR_W) : CNT_W'(SHORT_W);
  assign last_fall = fall && (bit_cnt == nbits);
  assign busy_o    = (state_q != ST_IDLE);

  adc_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sck_en),
    .div_i  (div_q),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_frame_shift #(.FR_W(FR_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (rise),
    .bit_i   (sdo_i),
    .frame_o (frame),
    .cnt_o   (bit_cnt)
  );

  adc_frame_decode #(.DATA_W(DATA_W), .TRL_W(TRL_W)) u_dec (
    .frame_i  (frame),
    .long_i   (long_q),
    .result_o (dec_res),
    .over_o   (dec_over),
    .under_o  (dec_under),
    .err_o    (dec_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cs_no       <= 1'b1;
      long_q      <= 1'b0;
      div_q       <= '0;
      wait_q      <= '0;
      valid_o     <= 1'b0;
      timeout_o   <= 1'b0;
      result_o    <= '0;
      over_o      <= 1'b0;
      under_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          cs_no   <= 1'b0;
          long_q  <= long_frame_i;
          div_q   <= div_i;
          wait_q  <= '0;
        end
        ST_WAIT: begin
          // end of conversion wins over an expiring timeout
          if (!sdo_i) begin
            state_q <= ST_SHIFT;
          end else if (wait_q == timeout_i) begin
            state_q   <= ST_IDLE;
            cs_no     <= 1'b1;
            timeout_o <= 1'b1;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_SHIFT: if (last_fall) begin
          state_q <= ST_DONE;
          cs_no   <= 1'b1;
        end
        ST_DONE: begin
          state_q     <= ST_IDLE;
          valid_o     <= 1'b1;
          result_o    <= dec_res;
          over_o      <= dec_over;
          under_o     <= dec_under;
          frame_err_o <= dec_err;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic busy_o,
  input logic valid_o,
  input logic over_o,
  input logic under_o,
  input logic timeout_o
);
  AST_SCK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no); // R3
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sck_o)); // R1
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_RANGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_o && under_o)); // R6
  AST_VALID_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no); // R4
  AST_TIMEOUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (cs_no && !valid_o)); // R9
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R9
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_no     (cs_no),
  .sck_o     (sck_o),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .over_o    (over_o),
  .under_o   (under_o),
  .timeout_o (timeout_o)
);

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        long_frame_i = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic [15:0] timeout_i = 16'd50;
  logic        sdo_i;
  logic        cs_no, sck_o, busy_o, valid_o, over_o, under_o, frame_err_o, timeout_o;
  logic [21:0] result_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = !clk_i;

  adc_frame_reader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .long_frame_i(long_frame_i),
    .div_i(div_i), .timeout_i(timeout_i), .sdo_i(sdo_i), .cs_no(cs_no), .sck_o(sck_o),
    .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o), .over_o(over_o),
    .under_o(under_o), .frame_err_o(frame_err_o), .timeout_o(timeout_o)
  );

  // converter model
  logic [31:0] m_frame = 32'hFFFF_FFFF;
  int          m_dly = 0;
  int          m_cnt = 0;
  int          m_idx = 0;

  always @(posedge clk_i) begin
    if (cs_no) m_cnt <= 0;
    else       m_cnt <= m_cnt + 1;
  end

  always @(negedge sck_o or posedge cs_no) begin
    if (cs_no) m_idx <= 0;
    else       m_idx <= m_idx + 1;
  end

  always_comb begin
    if (cs_no)              sdo_i = 1'b1;
    else if (m_cnt < m_dly) sdo_i = 1'b1;
    else if (m_idx < 32)    sdo_i = m_frame[31 - m_idx];
    else                    sdo_i = 1'b1;
  end

  // monitor of serial clock
  int   rises = 0;
  int   hi_cyc = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk_i) begin
    if (sck_o && !sck_prev) rises <= rises + 1;
    if (sck_o) hi_cyc <= hi_cyc + 1;
    sck_prev <= sck_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        lng;
    logic [7:0]  div;
    logic [7:0]  dly;
    logic        dmy;
    logic        sig;
    logic        exr;
    logic [19:0] dat;
    logic [7:0]  trl;
    logic [21:0] res;
    logic        ov;
    logic        un;
    logic        err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1, 8'd3, 1'b0, 1'b1, 1'b0, 20'h80000, 8'hFF, 22'h080000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd2, 8'd0, 1'b0, 1'b1, 1'b1, 20'h1FFFF, 8'hFF, 22'h11FFFF, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'd3, 8'd5, 1'b0, 1'b0, 1'b1, 20'hFFFFF, 8'hFF, 22'h3FFFFF, 1'b0, 1'b1, 1'b0},
    '{1'b1, 8'd1, 8'd2, 1'b0, 1'b0, 1'b1, 20'hE0000, 8'hFF, 22'h3E0000, 1'b0, 1'b1, 1'b0},
    '{1'b1, 8'd2, 8'd1, 1'b0, 1'b1, 1'b0, 20'h12345, 8'hFE, 22'h012345, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'd1, 8'd0, 1'b1, 1'b1, 1'b0, 20'h00001, 8'hFF, 22'h000001, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'd4, 8'd7, 1'b0, 1'b1, 1'b0, 20'h00000, 8'hFF, 22'h000000, 1'b0, 1'b0, 1'b0}
  };

  bit got_valid, got_to;

  task automatic run(input bit lng, input logic [7:0] dv, input int dly,
                     input logic [31:0] fr, input bit poke_start);
    int n;
    got_valid = 1'b0;
    got_to = 1'b0;
    @(negedge clk_i);
    long_frame_i = lng;
    div_i = dv;
    m_dly = dly;
    m_frame = fr;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!cs_no, "R2 cs low after start", cs_no, 0);
    n = 0;
    while (!valid_o && !timeout_o && n < 5000) begin
      @(negedge clk_i);
      n++;
      if (poke_start && n == 20) start_i = 1'b1;
      if (poke_start && n == 21) start_i = 1'b0;
    end
    got_valid = valid_o;
    got_to = timeout_o;
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, h0, nb;
    logic [31:0] fr;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(cs_no && !sck_o && !busy_o && !valid_o && !timeout_o, "R1 reset state",
          {cs_no, sck_o, busy_o, valid_o, timeout_o}, 5'b10000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      fr = {1'b0, v.dmy, v.sig, v.exr, v.dat, v.trl};
      if (!v.lng) fr = {fr[31:8], 8'hFF};
      r0 = rises;
      h0 = hi_cyc;
      timeout_i = 16'd50;
      run(v.lng, v.div, int'(v.dly), fr, 1'b0);
      nb = v.lng ? 32 : 24;
      check(got_valid && !got_to, "R4 frame completes", {got_valid, got_to}, 2'b10);
      check(rises - r0 == nb, "R4 rising edge count", rises - r0, nb);
      check(hi_cyc - h0 == nb * int'(v.div), "R3 half period", hi_cyc - h0, nb * int'(v.div));
      check(result_o == v.res, "R5 result", result_o, v.res);
      check(over_o == v.ov && under_o == v.un, "R6 range flags",
            {over_o, under_o}, {v.ov, v.un});
      check(frame_err_o == v.err, v.lng ? "R8 trailer check" : "R7 status check",
            frame_err_o, v.err);
      check(cs_no, "R4 cs high at valid", cs_no, 1);
      @(negedge clk_i);
      check(!valid_o, "R6 valid one cycle", valid_o, 0);
    end

    // R3: div 0 behaves as 1
    r0 = rises;
    h0 = hi_cyc;
    run(1'b0, 8'd0, 0, {4'b0010, 20'h00ABC, 8'hFF}, 1'b0);
    check(hi_cyc - h0 == 24, "R3 div zero", hi_cyc - h0, 24);
    check(result_o == 22'h000ABC, "R5 div zero result", result_o, 22'h000ABC);

    // R9 tie: conversion ends on the same cycle the timeout would fire
    timeout_i = 16'd5;
    r0 = rises;
    run(1'b0, 8'd1, 5, {4'b0010, 20'h54321, 8'hFF}, 1'b0);
    check(got_valid && !got_to, "R9 eoc wins tie", {got_valid, got_to}, 2'b10);
    check(result_o == 22'h054321, "R9 tie result", result_o, 22'h054321);

    // R9 timeout one cycle later; R2 no clocks while waiting
    r0 = rises;
    run(1'b0, 8'd1, 6, {4'b0010, 20'h11111, 8'hFF}, 1'b0);
    check(got_to && !got_valid, "R9 timeout", {got_valid, got_to}, 2'b01);
    check(rises == r0, "R2 no clock while busy converting", rises - r0, 0);
    check(cs_no, "R9 cs high on timeout", cs_no, 1);
    check(result_o == 22'h054321, "R9 result held", result_o, 22'h054321);
    @(negedge clk_i);
    check(!timeout_o, "R9 timeout one cycle", timeout_o, 0);

    // R10 start during a transfer is ignored
    timeout_i = 16'd50;
    r0 = rises;
    run(1'b0, 8'd2, 0, {4'b0011, 20'h0F0F0, 8'hFF}, 1'b1);
    check(rises - r0 == 24, "R10 single frame", rises - r0, 24);
    repeat (5) @(negedge clk_i);
    check(cs_no && !busy_o, "R10 no second reading", {cs_no, busy_o}, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule